// File: doc/BRIEF.md
# Banked GPIO Register Interface

This block is the register front end of a general-purpose pin controller with up to 128 lines, organised as four banks of 32. Pin `n` lives in bank `n >> 5`, bit `n & 31`. For each bank it keeps a direction word, an output latch, and two alternate-function words. Software changes the output latch only through a set port and a clear port, so a single write never needs a read-modify-write. A level register per bank returns, pin by pin, either the output latch or the sampled input, depending on direction.

The block is reached over a simple register bus: a 12-bit byte address, a write enable, a read strobe and a 32-bit write data word. Read data is registered and is valid one cycle after the strobe. Pin inputs arrive already synchronised. Pin outputs are the output latch gated by direction. Edge detection, interrupts, pad control and the meaning of alternate-function codes belong to other blocks. A parameter limits how many lines are implemented, and unimplemented direction and latch bits stay at zero.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every direction, output-latch and alternate-function word is zero, `pin_out_o` is zero, `rdata_o` is zero and `rd_notify_o` is low.
- R2: Banks 0 to 2 decode level at 0x000+4b, direction at 0x00C+4b, set at 0x018+4b and clear at 0x024+4b. Bank 3 decodes the same four registers at 0x100, 0x10C, 0x118 and 0x124. Direction bit 1 means output.
- R3: A write to a bank's set port ORs the write data into that bank's output latch.
- R4: A write to a bank's clear port clears every latch bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A read of any set or clear port returns zero.
- R6: A level read returns, per bit, the latch bit where direction is 1 and the `pin_in_i` bit sampled at the read strobe where direction is 0.
- R7: `pin_out_o` equals the output latch ANDed with direction for every bank. It reflects a write to direction, set or clear from the cycle after that write.
- R8: Alternate-function words are plain read/write storage: the low word of bank b is at 0x054+8b and the high word is at 0x058+8b.
- R9: An address of 0x200 or above, an unmapped offset, or an address with nonzero bits [1:0] reads as zero, and a write to it changes no register.
- R10: `rd_notify_o` is a one-cycle pulse in the cycle after a read strobe on any level register, aligned with the read data. It is low after every other access.
- R11: `rdata_o` is valid exactly one cycle after `re_i`. When `re_i` and `we_i` target the same register in the same cycle, the read returns the value from before the write.
- R12: With parameter `NUM_LINES` below 128, direction and latch bits for lines at or above `NUM_LINES` read as zero and drive zero, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the access |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid one cycle after `re_i` |
| rd_notify_o | output | 1 | Pulse after a level-register read |
| pin_in_i | input | 128 | Synchronised pin inputs, bit n is line n |
| pin_out_o | output | 128 | Pin output values, bit n is line n |

## Verification
A read and a write can fall in the same cycle. Then the registered read path and the register update compete for the same state. The bench drives `re_i` and `we_i` together on a direction word and expects the old value, then reads again and expects the new one. A level read can also coincide with a change of `pin_in_i` on input pins. This is provoked by changing the random pin inputs just before every level strobe and comparing against a model that samples the inputs at that strobe.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned PIN_W     = NUM_BANKS * BANK_W;

  typedef enum logic [2:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_AF_LO, K_AF_HI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  // Fixed map: banks 0..2 in the low window, bank 3 in the 0x100 window.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t   s;
    logic [5:0] w;
    logic [5:0] grp;
    s.kind = K_NONE;
    s.bank = 2'd0;
    w      = a[7:2];
    grp    = w / 6'd3;
    if (a[11:9] == 3'd0 && a[1:0] == 2'd0) begin
      if (a[8]) begin
        s.bank = 2'd3;
        case (w)
          6'd0:    s.kind = K_LEVEL;
          6'd3:    s.kind = K_DIR;
          6'd6:    s.kind = K_SET;
          6'd9:    s.kind = K_CLR;
          default: s.kind = K_NONE;
        endcase
      end else if (w < 6'd12) begin
        s.bank = 2'(w % 6'd3);
        case (grp)
          6'd0:    s.kind = K_LEVEL;
          6'd1:    s.kind = K_DIR;
          6'd2:    s.kind = K_SET;
          default: s.kind = K_CLR;
        endcase
      end else if (w >= 6'd21 && w <= 6'd28) begin
        s.bank = 2'((w - 6'd21) >> 1);
        s.kind = ((w - 6'd21) & 6'd1) != 6'd0 ? K_AF_HI : K_AF_LO;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  output reg_sel_t             sel_o,
  output logic [NUM_BANKS-1:0] dir_we_o,
  output logic [NUM_BANKS-1:0] set_we_o,
  output logic [NUM_BANKS-1:0] clr_we_o,
  output logic [NUM_BANKS-1:0] af_lo_we_o,
  output logic [NUM_BANKS-1:0] af_hi_we_o
);
  reg_sel_t sel;

  always_comb begin
    sel = decode_addr(addr_i);
    for (int b = 0; b < NUM_BANKS; b++) begin
      dir_we_o[b]   = we_i && sel.bank == 2'(b) && sel.kind == K_DIR;
      set_we_o[b]   = we_i && sel.bank == 2'(b) && sel.kind == K_SET;
      clr_we_o[b]   = we_i && sel.bank == 2'(b) && sel.kind == K_CLR;
      af_lo_we_o[b] = we_i && sel.bank == 2'(b) && sel.kind == K_AF_LO;
      af_hi_we_o[b] = we_i && sel.bank == 2'(b) && sel.kind == K_AF_HI;
    end
  end

  assign sel_o = sel;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] LINE_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_we_i,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic              af_lo_we_i,
  input  logic              af_hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pin_in_i,
  output logic [DATA_W-1:0] dir_o,
  output logic [DATA_W-1:0] level_o,
  output logic [DATA_W-1:0] af_lo_o,
  output logic [DATA_W-1:0] af_hi_o,
  output logic [DATA_W-1:0] pin_out_o
);
  logic [DATA_W-1:0] dir_q, out_q, af_lo_q, af_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      af_lo_q <= '0;
      af_hi_q <= '0;
    end else begin
      if (dir_we_i)   dir_q   <= wdata_i & LINE_MASK;
      if (set_we_i)   out_q   <= (out_q | wdata_i) & LINE_MASK;
      else if (clr_we_i) out_q <= out_q & ~wdata_i;
      if (af_lo_we_i) af_lo_q <= wdata_i;
      if (af_hi_we_i) af_hi_q <= wdata_i;
    end
  end

  assign dir_o     = dir_q;
  assign af_lo_o   = af_lo_q;
  assign af_hi_o   = af_hi_q;
  assign pin_out_o = out_q & dir_q;
  assign level_o   = (out_q & dir_q) | (pin_in_i & ~dir_q);

  p_set_ors_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((out_q & $past(wdata_i & LINE_MASK)) == $past(wdata_i & LINE_MASK))
                 && ((out_q & $past(out_q)) == $past(out_q)));

  p_clr_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((out_q & $past(wdata_i)) == '0)
                                && (out_q == ($past(out_q) & ~$past(wdata_i))));

  p_masked_bits_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dir_q | out_q) & ~LINE_MASK) == '0);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rd_notify_o,
  input  logic [127:0]      pin_in_i,
  output logic [127:0]      pin_out_o
);
  function automatic logic [BANK_W-1:0] bank_mask(input int unsigned b);
    logic [BANK_W-1:0] m;
    for (int unsigned i = 0; i < BANK_W; i++) m[i] = (b * BANK_W + i) < NUM_LINES;
    return m;
  endfunction

  reg_sel_t             sel;
  logic [NUM_BANKS-1:0] dir_we, set_we, clr_we, af_lo_we, af_hi_we;
  logic [BANK_W-1:0]    dir_w   [NUM_BANKS];
  logic [BANK_W-1:0]    level_w [NUM_BANKS];
  logic [BANK_W-1:0]    af_lo_w [NUM_BANKS];
  logic [BANK_W-1:0]    af_hi_w [NUM_BANKS];
  logic [BANK_W-1:0]    rd_val;
  logic [BANK_W-1:0]    rdata_q;
  logic                 notify_q;

  gpio_addr_decode u_dec (
    .addr_i     (addr_i),
    .we_i       (we_i),
    .sel_o      (sel),
    .dir_we_o   (dir_we),
    .set_we_o   (set_we),
    .clr_we_o   (clr_we),
    .af_lo_we_o (af_lo_we),
    .af_hi_we_o (af_hi_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] MASK = bank_mask(b);
    gpio_bank #(.DATA_W(BANK_W), .LINE_MASK(MASK)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dir_we_i   (dir_we[b]),
      .set_we_i   (set_we[b]),
      .clr_we_i   (clr_we[b]),
      .af_lo_we_i (af_lo_we[b]),
      .af_hi_we_i (af_hi_we[b]),
      .wdata_i    (wdata_i),
      .pin_in_i   (pin_in_i[b*BANK_W +: BANK_W]),
      .dir_o      (dir_w[b]),
      .level_o    (level_w[b]),
      .af_lo_o    (af_lo_w[b]),
      .af_hi_o    (af_hi_w[b]),
      .pin_out_o  (pin_out_o[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    case (sel.kind)
      K_LEVEL: rd_val = level_w[sel.bank];
      K_DIR:   rd_val = dir_w[sel.bank];
      K_AF_LO: rd_val = af_lo_w[sel.bank];
      K_AF_HI: rd_val = af_hi_w[sel.bank];
      default: rd_val = '0;  // set/clear ports and holes read zero
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      notify_q <= 1'b0;
    end else begin
      rdata_q  <= re_i ? rd_val : '0;
      notify_q <= re_i && sel.kind == K_LEVEL;
    end
  end

  assign rdata_o     = rdata_q;
  assign rd_notify_o = notify_q;

  p_wo_port_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (addr_i == 12'h018 || addr_i == 12'h124)) |=> rdata_o == '0);

  p_far_addr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i >= 12'h200) |=> rdata_o == '0);

  p_notify_after_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_notify_o |-> $past(re_i));

  p_notify_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_notify_o |=> !rd_notify_o || $past(re_i));

  p_drive_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o[31:0] & ~dir_w[0]) == '0);
endmodule

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  addr = '0;
  logic         we = 1'b0, re = 1'b0;
  logic [31:0]  wdata = '0;
  logic [127:0] pin_in = '0;
  logic [31:0]  rdata, rdata_n;
  logic         notify, notify_n;
  logic [127:0] pin_out, pin_out_n;

  int unsigned n_tests = 0, n_fail = 0;
  logic [31:0] m_dir [4];
  logic [31:0] m_out [4];
  logic [31:0] m_af  [8];

  always #5 clk = ~clk;

  gpio_bank_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .rd_notify_o(notify),
    .pin_in_i(pin_in), .pin_out_o(pin_out));

  gpio_bank_regs #(.NUM_LINES(40)) dut_n (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata_n), .rd_notify_o(notify_n),
    .pin_in_i(pin_in), .pin_out_o(pin_out_n));

  function automatic logic [11:0] a_lvl(int b); return b == 3 ? 12'h100 : 12'(4 * b); endfunction
  function automatic logic [11:0] a_dir(int b); return a_lvl(b) + 12'h00C; endfunction
  function automatic logic [11:0] a_set(int b); return a_lvl(b) + 12'h018; endfunction
  function automatic logic [11:0] a_clr(int b); return a_lvl(b) + 12'h024; endfunction
  function automatic logic [11:0] a_afl(int b); return 12'h054 + 12'(8 * b); endfunction
  function automatic logic [11:0] a_afh(int b); return 12'h058 + 12'(8 * b); endfunction

  function automatic logic [127:0] exp_pins();
    logic [127:0] v;
    for (int b = 0; b < 4; b++) v[b*32 +: 32] = m_out[b] & m_dir[b];
    return v;
  endfunction

  function automatic logic [31:0] exp_level(int b);
    return (m_out[b] & m_dir[b]) | (pin_in[b*32 +: 32] & ~m_dir[b]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; re = 1'b0;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input bit exp_ntf, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1; we = 1'b0;
    @(negedge clk);
    re = 1'b0;
    chk(rdata == exp, tag, 128'(rdata), 128'(exp));
    chk(notify == exp_ntf, {tag, " R10 notify"}, 128'(notify), 128'(exp_ntf));
  endtask

  task automatic model_wr(input logic [11:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) begin
      if (a == a_dir(b)) m_dir[b] = d;
      if (a == a_set(b)) m_out[b] = m_out[b] | d;
      if (a == a_clr(b)) m_out[b] = m_out[b] & ~d;
      if (a == a_afl(b)) m_af[2*b] = d;
      if (a == a_afh(b)) m_af[2*b+1] = d;
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    wr(a, d);
    model_wr(a, d);
    chk(pin_out == exp_pins(), tag, pin_out, exp_pins());
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) begin m_dir[i] = '0; m_out[i] = '0; end
    for (int i = 0; i < 8; i++) m_af[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pin_out == '0, "R1 pin_out", pin_out, '0);
    chk(rdata == '0 && !notify, "R1 rdata/notify", 128'(rdata), '0);
    rst_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      rd(a_dir(b), 32'h0, 1'b0, "R1 dir");
      rd(a_afl(b), 32'h0, 1'b0, "R1 af_lo");
      rd(a_afh(b), 32'h0, 1'b0, "R1 af_hi");
    end

    // R2 R3 R4 R7 directed, each bank including bank 3 window
    for (int b = 0; b < 4; b++) begin
      do_wr(a_dir(b), 32'h0000_FFFF, "R2 dir write pins");
      rd(a_dir(b), 32'h0000_FFFF, 1'b0, "R2 dir readback");
      do_wr(a_set(b), 32'hF0F0_F0F0, "R3 set pins");
      do_wr(a_set(b), 32'h0000_000F, "R3 set or pins");
      do_wr(a_clr(b), 32'h00F0_0003, "R4 clr pins");
      pin_in = {4{32'hA5A5_5A5A}};
      rd(a_lvl(b), exp_level(b), 1'b1, "R6 level merge");
      rd(a_set(b), 32'h0, 1'b0, "R5 set reads zero");
      rd(a_clr(b), 32'h0, 1'b0, "R5 clr reads zero");
    end

    // R8 alternate-function storage
    for (int b = 0; b < 4; b++) begin
      do_wr(a_afl(b), 32'h1100_0000 + 32'(b), "R8 af lo write");
      do_wr(a_afh(b), 32'h2200_0000 + 32'(b), "R8 af hi write");
    end
    for (int b = 0; b < 4; b++) begin
      rd(a_afl(b), m_af[2*b], 1'b0, "R8 af lo read");
      rd(a_afh(b), m_af[2*b+1], 1'b0, "R8 af hi read");
    end

    // R9 out-of-range, unmapped and misaligned accesses
    do_wr(12'h20C, 32'hDEAD_BEEF, "R9 far write pins");
    do_wr(12'h048, 32'hDEAD_BEEF, "R9 hole write pins");
    do_wr(12'h00D, 32'hDEAD_BEEF, "R9 misaligned write pins");
    do_wr(12'h200, 32'hFFFF_FFFF, "R9 far level write pins");
    rd(a_dir(0), m_dir[0], 1'b0, "R9 dir untouched");
    rd(12'h20C, 32'h0, 1'b0, "R9 far read zero");
    rd(12'h200, 32'h0, 1'b0, "R9 far level no notify");
    rd(12'h048, 32'h0, 1'b0, "R9 hole read zero");
    rd(12'h10D, 32'h0, 1'b0, "R9 misaligned read zero");
    rd(12'h104, 32'h0, 1'b0, "R9 bank3 window hole");

    // R11 read and write in one cycle: old value first
    @(negedge clk);
    addr = a_dir(0); wdata = 32'h1234_5678; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    chk(rdata == m_dir[0], "R11 same-cycle old value", 128'(rdata), 128'(m_dir[0]));
    model_wr(a_dir(0), 32'h1234_5678);
    rd(a_dir(0), 32'h1234_5678, 1'b0, "R11 new value after");
    @(negedge clk);
    chk(rdata == '0 && !notify, "R11 R10 idle after read", 128'(rdata), '0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int b, op;
      logic [31:0] d;
      b = int'($urandom_range(0, 3));
      op = int'($urandom_range(0, 6));
      d = $urandom();
      pin_in = {$urandom(), $urandom(), $urandom(), $urandom()};
      case (op)
        0: do_wr(a_dir(b), d, "R2 R7 rand dir");
        1: do_wr(a_set(b), d, "R3 rand set");
        2: do_wr(a_clr(b), d, "R4 rand clr");
        3: do_wr(($urandom_range(0, 1) != 0) ? a_afl(b) : a_afh(b), d, "R8 rand af");
        4: rd(a_lvl(b), exp_level(b), 1'b1, "R6 rand level");
        5: rd(a_dir(b), m_dir[b], 1'b0, "R2 rand dir");
        default: rd(a_afh(b), m_af[2*b+1], 1'b0, "R8 rand af read");
      endcase
    end

    // R12 narrow instance, 40 lines
    pin_in = '0;
    wr(a_dir(1), 32'hFFFF_FFFF);
    wr(a_set(1), 32'hFFFF_FFFF);
    wr(a_dir(2), 32'hFFFF_FFFF);
    wr(a_set(2), 32'hFFFF_FFFF);
    chk(pin_out_n[127:32] == {64'h0, 32'h0000_00FF}, "R12 narrow pins", pin_out_n, {64'h0, 32'h0000_00FF, 32'h0});
    @(negedge clk); addr = a_dir(1); re = 1'b1;
    @(negedge clk); re = 1'b0;
    chk(rdata_n == 32'h0000_00FF, "R12 narrow dir", 128'(rdata_n), 128'h0FF);
    @(negedge clk); addr = a_lvl(2); re = 1'b1;
    @(negedge clk); re = 1'b0;
    chk(rdata_n == 32'h0, "R12 narrow level bank2", 128'(rdata_n), '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule